// File: doc/BRIEF.md
# SD Card Single-Block Data Transfer Engine

This block carries out the data phase of a single-block SD card transfer in SPI mode. Once the read or write command has been accepted by the card, the controller starts the engine. The engine drives the card's chip select and a byte-exchange port on an SPI shifter. On the local side it moves the block payload over valid/ready byte streams. On a read it hunts for the start token, delivers the payload and discards the CRC. On a write it sends the start token, the payload and dummy CRC bytes, then checks the card's data response token and waits out the busy period.

Every transfer ends the same way. Chip select is raised, one trailing 0xFF byte is clocked, and a one-cycle completion pulse is raised together with an error code. The engine also captures the card address for the associated command when it starts: the block number is scaled by the sector size for byte-addressed cards and left unscaled for block-addressed cards. The payload length is a parameter, so the same engine can also fetch short register blocks.

Top module: `sdx_block_engine`

## Requirements
- R1: After reset, cs_n is 1, xg_go is 0, active is 0, done is 0, rd_valid is 0 and err_code is 0.
- R2: On a start, card_addr takes blk_num shifted left by log2(SECTOR_BYTES) when blk_addr_mode is 0, and takes blk_num unchanged when blk_addr_mode is 1.
- R3: A read (dir_write=0) sends 0xFF on every exchange and discards received bytes until 0xFE arrives. The next BLOCK_BYTES received bytes are delivered in order on rd_data. rd_data is held stable while rd_valid is 1 and rd_ready is 0, and no further data exchange starts until the byte is taken.
- R4: After the payload of a read, two more 0xFF exchanges are made and their bytes dropped. The transfer then finishes with a one-cycle done pulse and err_code 0.
- R5: A read that receives HUNT_LIMIT consecutive bytes none of which is 0xFE finishes with err_code 4. A 0xFE arriving as byte number HUNT_LIMIT still succeeds.
- R6: A write (dir_write=1) sends 0xFE, then BLOCK_BYTES bytes taken from the write stream in order, then two 0xFF bytes. One more 0xFF exchange then fetches the response token.
- R7: Only the low five bits of the token are examined. 5'b00101 means accepted. 5'b01011 ends with err_code 1 (CRC rejected), 5'b01101 with err_code 2 (write rejected), and any other value with err_code 3. A rejected write has no busy phase.
- R8: After an accepted token, 0xFF exchanges repeat while the card returns 0x00. The first nonzero byte ends the busy wait with err_code 0.
- R9: BUSY_LIMIT consecutive 0x00 bytes after an accepted token end the transfer with err_code 5. A nonzero byte arriving as busy byte number BUSY_LIMIT still succeeds.
- R10: cs_n is 0 for every exchange of a transfer except the last, which is a 0xFF exchange with cs_n 1 that precedes done. A start while active is ignored.
- R11: At most one exchange is outstanding: after xg_go, no new xg_go comes before xg_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| dir_write | input | 1 | 1 = write block, 0 = read block |
| blk_num | input | BLK_W | Block number for the transfer |
| blk_addr_mode | input | 1 | 1 = card is block addressed, 0 = byte addressed |
| card_addr | output | ADDR_W | Address to place in the command argument |
| active | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result: 0 ok, 1 CRC rejected, 2 write rejected, 3 bad token, 4 start-token timeout, 5 busy timeout |
| cs_n | output | 1 | Card chip select, active low |
| xg_go | output | 1 | One-cycle request for a byte exchange |
| xg_tx | output | 8 | Byte to shift out |
| xg_ack | input | 1 | Exchange finished, xg_rx valid |
| xg_rx | input | 8 | Byte shifted in |
| rd_valid | output | 1 | Read payload byte available |
| rd_data | output | 8 | Read payload byte |
| rd_ready | input | 1 | Consumer takes the read byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_data | input | 8 | Write payload byte |
| wr_ready | output | 1 | Engine takes the write byte |

## Verification
The bench places the start token exactly at the hunt limit and one byte past it. It does the same with the end of the busy period. An off-by-one counter would make one of each pair flip between success and timeout. Response tokens carry junk in their upper three bits, so a design comparing the whole byte would reject a good write, and each reject pattern must map to its own code. Back-pressure on both streams checks that no read byte is lost or duplicated and no write byte is sent twice. Every exchange log is checked for chip select low on all but the single trailing byte, so a missing or extra trailer shows up as a wrong exchange count.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  typedef enum logic [2:0] {
    SDX_OK      = 3'd0,
    SDX_CRC_REJ = 3'd1,
    SDX_WR_REJ  = 3'd2,
    SDX_BAD_TOK = 3'd3,
    SDX_HUNT_TO = 3'd4,
    SDX_BUSY_TO = 3'd5
  } sdx_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_STOK, ST_DATA, ST_CRC, ST_RESP, ST_BUSY, ST_TAIL
  } sdx_state_e;

  localparam logic [7:0] SDX_START_TOK = 8'hFE;
  localparam logic [7:0] SDX_IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/sdx_addr_scale.sv
module sdx_addr_scale #(
  parameter int BLK_W        = 32,
  parameter int ADDR_W       = 32,
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BLK_W-1:0]  blk,
  input  logic              blk_mode,
  output logic [ADDR_W-1:0] addr
);
  localparam int SECT_SH = $clog2(SECTOR_BYTES);

  logic [ADDR_W-1:0] byte_addr;
  generate
    if (SECT_SH == 0) begin : g_noshift
      assign byte_addr = ADDR_W'(blk);
    end else begin : g_shift
      assign byte_addr = ADDR_W'(blk) << SECT_SH;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= blk_mode ? ADDR_W'(blk) : byte_addr;
  end

  // R2: block-addressed load keeps the raw number's low bit
  assert_addr_raw_R2: assert property (@(posedge clk) disable iff (rst)
    (load && blk_mode) |=> (addr[0] == $past(blk[0])));
endmodule

// File: rtl/sdx_limit_counter.sv
module sdx_limit_counter #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == CW'(LIMIT - 1));

  // R5 / R9: the owner must stop counting once the limit is reached
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    !(inc && at_last && !clr));
endmodule

// File: rtl/sdx_token_decode.sv
module sdx_token_decode
  import sdx_pkg::*;
(
  input  logic [4:0] tok,
  output sdx_err_e   verdict
);
  always_comb begin
    case (tok)
      5'b00101: verdict = SDX_OK;
      5'b01011: verdict = SDX_CRC_REJ;
      5'b01101: verdict = SDX_WR_REJ;
      default:  verdict = SDX_BAD_TOK;
    endcase
  end
endmodule

// File: rtl/sdx_block_engine.sv
module sdx_block_engine
  import sdx_pkg::*;
#(
  parameter int BLOCK_BYTES  = 512,
  parameter int SECTOR_BYTES = 512,
  parameter int BLK_W        = 32,
  parameter int ADDR_W       = 32,
  parameter int HUNT_LIMIT   = 5000,
  parameter int BUSY_LIMIT   = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_write,
  input  logic [BLK_W-1:0]  blk_num,
  input  logic              blk_addr_mode,
  output logic [ADDR_W-1:0] card_addr,
  output logic              active,
  output logic              done,
  output logic [2:0]        err_code,
  output logic              cs_n,
  output logic              xg_go,
  output logic [7:0]        xg_tx,
  input  logic              xg_ack,
  input  logic [7:0]        xg_rx,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              rd_ready,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready
);
  localparam int CNT_W = (BLOCK_BYTES < 2) ? 1 : $clog2(BLOCK_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_BYTES - 1);

  sdx_state_e       state;
  sdx_err_e         err_q, tok_verdict;
  logic             pend, is_wr;
  logic [CNT_W-1:0] cnt;
  logic             issue, got;
  logic [7:0]       tx_next;
  logic             hunt_last, busy_last, hunt_inc, busy_inc;
  logic             launch;

  assign launch = (state == ST_IDLE) && start;
  assign got    = pend && xg_ack;

  sdx_addr_scale #(
    .BLK_W(BLK_W), .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)
  ) i_addr (
    .clk(clk), .rst(rst), .load(launch), .blk(blk_num),
    .blk_mode(blk_addr_mode), .addr(card_addr)
  );

  assign hunt_inc = got && (state == ST_HUNT) && (xg_rx != SDX_START_TOK) && !hunt_last;
  assign busy_inc = got && (state == ST_BUSY) && (xg_rx == 8'h00) && !busy_last;

  sdx_limit_counter #(.LIMIT(HUNT_LIMIT)) i_hunt_cnt (
    .clk(clk), .rst(rst), .clr(state != ST_HUNT), .inc(hunt_inc), .at_last(hunt_last)
  );

  sdx_limit_counter #(.LIMIT(BUSY_LIMIT)) i_busy_cnt (
    .clk(clk), .rst(rst), .clr(state != ST_BUSY), .inc(busy_inc), .at_last(busy_last)
  );

  sdx_token_decode i_tok (.tok(xg_rx[4:0]), .verdict(tok_verdict));

  // next exchange: payload exchanges wait for stream space or data
  always_comb begin
    issue = (state != ST_IDLE) && !pend;
    if (state == ST_DATA) issue = issue && (is_wr ? wr_valid : !rd_valid);
    if (state == ST_STOK)                tx_next = SDX_START_TOK;
    else if (state == ST_DATA && is_wr)  tx_next = wr_data;
    else                                 tx_next = SDX_IDLE_BYTE;
  end

  assign wr_ready = (state == ST_DATA) && is_wr && !pend;
  assign active   = (state != ST_IDLE);
  assign err_code = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pend     <= 1'b0;
      is_wr    <= 1'b0;
      cnt      <= '0;
      xg_go    <= 1'b0;
      xg_tx    <= SDX_IDLE_BYTE;
      cs_n     <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      done     <= 1'b0;
      err_q    <= SDX_OK;
    end else begin
      xg_go <= 1'b0;
      done  <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;

      if (launch) begin
        is_wr <= dir_write;
        cs_n  <= 1'b0;
        err_q <= SDX_OK;
        cnt   <= '0;
        state <= dir_write ? ST_STOK : ST_HUNT;
      end

      if (issue) begin
        xg_go <= 1'b1;
        pend  <= 1'b1;
        xg_tx <= tx_next;
      end

      if (got) begin
        pend <= 1'b0;
        case (state)
          ST_HUNT: begin
            if (xg_rx == SDX_START_TOK) begin
              state <= ST_DATA;
              cnt   <= '0;
            end else if (hunt_last) begin
              err_q <= SDX_HUNT_TO;
              cs_n  <= 1'b1;
              state <= ST_TAIL;
            end
          end
          ST_STOK: begin
            state <= ST_DATA;
            cnt   <= '0;
          end
          ST_DATA: begin
            if (!is_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= xg_rx;
            end
            if (cnt == LAST_IDX) begin
              cnt   <= '0;
              state <= ST_CRC;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_CRC: begin
            if (cnt[0]) begin
              cnt <= '0;
              if (is_wr) begin
                state <= ST_RESP;
              end else begin
                cs_n  <= 1'b1;
                state <= ST_TAIL;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_RESP: begin
            if (tok_verdict == SDX_OK) begin
              state <= ST_BUSY;
            end else begin
              err_q <= tok_verdict;
              cs_n  <= 1'b1;
              state <= ST_TAIL;
            end
          end
          ST_BUSY: begin
            if (xg_rx != 8'h00) begin
              cs_n  <= 1'b1;
              state <= ST_TAIL;
            end else if (busy_last) begin
              err_q <= SDX_BUSY_TO;
              cs_n  <= 1'b1;
              state <= ST_TAIL;
            end
          end
          ST_TAIL: begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: a presented read byte waits for the consumer
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R4: completion is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: select is released whenever the engine is idle
  assert_cs_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> cs_n);

  // R10: the final exchange goes out with select released
  assert_tail_cs_R10: assert property (@(posedge clk) disable iff (rst)
    (done) |-> $past(cs_n));

  // R11: no second request while one is outstanding
  assert_one_inflight_R11: assert property (@(posedge clk) disable iff (rst)
    (xg_go && !xg_ack) |=> !xg_go);
endmodule

// File: tb/test_sdx_block_engine.sv
module test_sdx_block_engine;
  localparam int N     = 16;
  localparam int HLIM  = 8;
  localparam int BLIM  = 6;
  localparam int LOGSZ = 128;

  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0, dir_write = 0, blk_addr_mode = 0;
  logic [31:0] blk_num = '0;
  logic [31:0] card_addr;
  logic        active, done, cs_n, xg_go, xg_ack = 0;
  logic [2:0]  err_code;
  logic [7:0]  xg_tx, xg_rx = 8'hFF;
  logic        rd_valid, rd_ready = 1, wr_valid = 0, wr_ready;
  logic [7:0]  rd_data, wr_data = 8'h00;

  always #10 clk = ~clk;

  sdx_block_engine #(
    .BLOCK_BYTES(N), .SECTOR_BYTES(512), .BLK_W(32), .ADDR_W(32),
    .HUNT_LIMIT(HLIM), .BUSY_LIMIT(BLIM)
  ) i_sdx_block_engine (
    .clk(clk), .rst(rst), .start(start), .dir_write(dir_write),
    .blk_num(blk_num), .blk_addr_mode(blk_addr_mode), .card_addr(card_addr),
    .active(active), .done(done), .err_code(err_code), .cs_n(cs_n),
    .xg_go(xg_go), .xg_tx(xg_tx), .xg_ack(xg_ack), .xg_rx(xg_rx),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  int checks = 0, errors = 0;

  // card model and stream models
  logic [7:0] resp   [0:LOGSZ-1];
  logic [7:0] log_tx [0:LOGSZ-1];
  logic       log_cs [0:LOGSZ-1];
  logic [7:0] rbuf   [0:LOGSZ-1];
  int ridx = 0, nx = 0, ack_cd = 0, rcnt = 0, widx = 0, tick = 0;
  bit rstall = 0, wstall = 0, wr_en = 0;
  bit go_overlap = 0;

  function automatic logic [7:0] wpat(int i);
    return 8'(i * 37 + 5);
  endfunction
  function automatic logic [7:0] rpat(int i);
    return 8'(i * 11 + 8'h21);
  endfunction

  always @(negedge clk) begin
    tick++;
    xg_ack = 0;
    if (ack_cd > 0) begin
      ack_cd--;
      if (ack_cd == 0) begin
        xg_ack = 1;
        xg_rx  = (ridx < LOGSZ) ? resp[ridx] : 8'hFF;
        ridx++;
      end
    end
    if (xg_go) begin
      if (ack_cd != 0) go_overlap = 1;
      if (nx < LOGSZ) begin log_tx[nx] = xg_tx; log_cs[nx] = cs_n; end
      nx++;
      ack_cd = 2;
    end
    rd_ready = rstall ? (tick % 3 == 0) : 1'b1;
    if (rd_valid && rd_ready) begin
      if (rcnt < LOGSZ) rbuf[rcnt] = rd_data;
      rcnt++;
    end
    wr_valid = wr_en && (wstall ? (tick % 4 != 1) : 1'b1);
    wr_data  = wpat(widx);
    if (wr_valid && wr_ready) widx++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(logic [7:0] v);
    for (int i = 0; i < LOGSZ; i++) resp[i] = v;
  endtask

  task automatic kick(bit wr, logic [31:0] blk, bit mode);
    nx = 0; ridx = 0; rcnt = 0; widx = 0; go_overlap = 0;
    wr_en = wr;
    @(negedge clk);
    start = 1; dir_write = wr; blk_num = blk; blk_addr_mode = mode;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output logic [2:0] e);
    bit got = 0;
    e = 3'd7;
    for (int i = 0; i < 4000 && !got; i++) begin
      @(negedge clk);
      if (done) begin got = 1; e = err_code; end
    end
    chk(got, "R4 done seen", int'(got), 1);
    repeat (6) @(negedge clk);
    wr_en = 0;
  endtask

  // every exchange low-select except the last, which is 0xFF high-select
  task automatic chk_frame(string req, int exp_n);
    bit ok = 1;
    chk(nx == exp_n, {req, " exchange count"}, nx, exp_n);
    for (int i = 0; i < nx - 1 && i < LOGSZ; i++) if (log_cs[i] !== 1'b0) ok = 0;
    chk(ok, "R10 select low during transfer", int'(ok), 1);
    if (nx > 0 && nx <= LOGSZ) begin
      chk(log_cs[nx-1] === 1'b1 && log_tx[nx-1] == 8'hFF, "R10 trailing byte",
          int'(log_cs[nx-1]), 1);
    end
    chk(!go_overlap, "R11 single outstanding exchange", int'(go_overlap), 0);
  endtask

  task automatic t_reset;
    chk(cs_n == 1 && xg_go == 0 && active == 0 && done == 0 && rd_valid == 0,
        "R1 reset outputs", int'({cs_n, xg_go, active, done, rd_valid}), 16);
    chk(err_code == 0, "R1 reset err", int'(err_code), 0);
  endtask

  task automatic chk_read_data(string req);
    bit ok = 1;
    chk(rcnt == N, {req, " byte count"}, rcnt, N);
    for (int i = 0; i < N && i < rcnt; i++) if (rbuf[i] != rpat(i)) ok = 0;
    chk(ok, {req, " payload order"}, int'(ok), 1);
  endtask

  task automatic t_read(int lead, bit stall, bit poke);
    logic [2:0] e;
    bit all_ff = 1;
    fill(8'hFF);
    for (int i = 0; i < lead; i++) resp[i] = (i % 2) ? 8'hFF : 8'h7E;
    resp[lead] = 8'hFE;
    for (int i = 0; i < N; i++) resp[lead + 1 + i] = rpat(i);
    resp[lead + 1 + N] = 8'h00; resp[lead + 2 + N] = 8'hFE;
    rstall = stall;
    kick(0, 32'h0000_0123, 0);
    chk(card_addr == 32'h0002_4600, "R2 byte addressed", int'(card_addr), 32'h24600);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; dir_write = 1;
      @(negedge clk);
      start = 0; dir_write = 0;
    end
    wait_done(e);
    chk(e == 0, "R4 read ok code", int'(e), 0);
    chk_read_data("R3");
    for (int i = 0; i < nx && i < LOGSZ; i++) if (log_tx[i] != 8'hFF) all_ff = 0;
    chk(all_ff, "R3 read sends only 0xFF", int'(all_ff), 1);
    chk_frame("R4", lead + 1 + N + 2 + 1);
    rstall = 0;
  endtask

  task automatic t_hunt_timeout;
    logic [2:0] e;
    fill(8'hFF);
    resp[HLIM] = 8'hFE;
    kick(0, 32'd7, 1);
    wait_done(e);
    chk(e == 4, "R5 hunt timeout code", int'(e), 4);
    chk(rcnt == 0, "R5 no data delivered", rcnt, 0);
    chk_frame("R5", HLIM + 1);
  endtask

  task automatic t_write(logic [7:0] tok, int zeros, int exp_e, bit stall, string req);
    logic [2:0] e;
    bit ok = 1;
    int exp_n;
    fill(8'hFF);
    resp[N + 3] = tok;
    for (int i = 0; i < zeros; i++) resp[N + 4 + i] = 8'h00;
    wstall = stall;
    kick(1, 32'h0000_0456, 1);
    chk(card_addr == 32'h0000_0456, "R2 block addressed", int'(card_addr), 32'h456);
    wait_done(e);
    chk(e == exp_e[2:0], {req, " result code"}, int'(e), exp_e);
    chk(log_tx[0] == 8'hFE, "R6 start token", int'(log_tx[0]), 8'hFE);
    for (int i = 0; i < N; i++) if (log_tx[1 + i] != wpat(i)) ok = 0;
    chk(ok && widx == N, "R6 payload order", widx, N);
    chk(log_tx[N+1] == 8'hFF && log_tx[N+2] == 8'hFF && log_tx[N+3] == 8'hFF,
        "R6 dummy crc and token poll", int'(log_tx[N+1]), 8'hFF);
    if (exp_e == 0) exp_n = 1 + N + 2 + 1 + zeros + 1 + 1;
    else if (exp_e == 5) exp_n = 1 + N + 2 + 1 + BLIM + 1;
    else exp_n = 1 + N + 2 + 1 + 1;
    chk_frame(req, exp_n);
    wstall = 0;
  endtask

  initial begin
    fill(8'hFF);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(2, 0, 0);               // R3 R4 basic read
    t_read(5, 1, 1);               // R3 back-pressure, R10 start ignored
    t_read(HLIM - 1, 0, 0);        // R5 token on the last allowed byte
    t_hunt_timeout();              // R5
    t_write(8'hE5, 3, 0, 0, "R8");       // R7 masking, R8 busy
    t_write(8'h05, BLIM - 1, 0, 1, "R9");// R9 boundary, R6 stall
    t_write(8'h0B, 0, 1, 0, "R7");       // CRC reject
    t_write(8'hED, 0, 2, 0, "R7");       // write reject with upper junk
    t_write(8'h07, 0, 3, 0, "R7");       // unknown token
    t_write(8'h25, BLIM + 4, 5, 0, "R9");// busy timeout
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule